// File: doc/BRIEF.md
# Link Training Controller

This block is a reduced link training state machine for a serial link. It takes a link from receiver detection through lock, configuration and rate negotiation into normal operation. It also handles the low-power states and recovery from failed or stalled training. The surrounding physical layer supplies event inputs: receiver present, lock achieved, configuration complete, equalization converged or failed, and a power-state request. The block answers with its current state, the data rate the physical layer should run at, and a one-cycle strobe that starts each equalization attempt.

Every waiting state has a cycle timeout, so the machine cannot stall. Equalization at the top rate is attempted first. Each failed or timed-out attempt lowers the rate by one step and starts equalization again. A failure at the base rate returns the machine to detection. Once the link is running below the top rate, a programmable interval counts down in normal operation, and when it expires the machine goes back to recovery to try the top rate again.

Top module: `link_train_fsm`

## Requirements
- R1: While rst_ni is low and after release, state_o is 0 (detect), rate_o is 0 and eq_start_o is 0. State codes are: 0 detect, 1 polling, 2 configuration, 3 recovery, 4 normal (L0), 5 L0s, 6 L1, 7 L2.
- R2: The machine moves from detect to polling when rx_detect_i is high. It moves from polling to configuration when lock_i is high, and from configuration to recovery when cfg_done_i is high. Each move is seen on state_o one clock after the input is sampled.
- R3: If polling or configuration stays unsatisfied for TMO_CYC consecutive cycles, state_o shows that state for exactly TMO_CYC cycles and then shows detect.
- R4: Rate codes are 0=2.5, 1=5, 2=8, 3=16 and 4=32 GT/s, and MAX_RATE defaults to 4. Entering recovery from configuration sets rate_o to MAX_RATE. eq_start_o is high for exactly the first cycle of each equalization attempt and only in recovery.
- R5: In recovery, eq_done_i moves the machine to L0. It takes priority over eq_fail_i and over the timeout in the same cycle.
- R6: In recovery with rate_o above 0, either eq_fail_i or TMO_CYC cycles without a result keeps the machine in recovery. rate_o drops by one code, eq_start_o pulses again and the timeout restarts.
- R7: In recovery with rate_o at 0, a failure or timeout returns the machine to detect.
- R8: In L0 with rate_o below MAX_RATE, the machine goes to recovery after retry_ival_i+1 cycles in L0, with rate_o set to MAX_RATE and eq_start_o pulsed. At MAX_RATE, L0 is held.
- R9: In L0, pwr_req_i of 1, 2 or 3 moves the machine to L0s, L1 or L2 respectively. A power request takes priority over the rate retry.
- R10: When pwr_req_i returns to 0, L0s goes back to L0, L1 goes to recovery with an eq_start_o pulse and rate_o unchanged, and L2 goes to detect with rate_o cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_detect_i | input | 1 | Receiver presence detected |
| lock_i | input | 1 | Bit and symbol lock achieved |
| cfg_done_i | input | 1 | Configuration complete |
| eq_done_i | input | 1 | Equalization converged |
| eq_fail_i | input | 1 | Equalization failed |
| pwr_req_i | input | 2 | Power request: 0 none, 1 L0s, 2 L1, 3 L2 |
| retry_ival_i | input | IVAL_W | L0 cycles before a top-rate retry, minus one |
| state_o | output | 3 | Current state code |
| rate_o | output | 3 | Target data rate code |
| eq_start_o | output | 1 | Start of an equalization attempt |

## Verification
The hardest situations to reach from the ports are the full descent from the top rate to the base rate and the rate retry after it. Both need a long run of recovery attempts that end in a timeout or a failure, followed by a stay in L0 at a reduced rate. The bench holds all result inputs low through five timeout windows to reach the base-rate exit to detect. It also combines a single failure with a zero retry interval and a same-cycle L1 request, which exercises the priority of power requests over the retry and the rate kept through an L1 exit.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int RATE_W = 3;

  typedef enum logic [2:0] {
    ST_DETECT = 3'd0,
    ST_POLL   = 3'd1,
    ST_CFG    = 3'd2,
    ST_RECOV  = 3'd3,
    ST_L0     = 3'd4,
    ST_L0S    = 3'd5,
    ST_L1     = 3'd6,
    ST_L2     = 3'd7
  } lt_state_e;
endpackage

// File: rtl/lt_timer.sv
module lt_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/lt_rate_ctl.sv
module lt_rate_ctl
  import lt_pkg::*;
#(
  parameter int MAX_RATE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_max_i,
  input  logic              dec_i,
  input  logic              clr_i,
  output logic [RATE_W-1:0] rate_o,
  output logic              at_min_o,
  output logic              below_max_o
);
  localparam logic [RATE_W-1:0] RMAX = RATE_W'(MAX_RATE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rate_o <= '0;
    else if (clr_i)    rate_o <= '0;
    else if (ld_max_i) rate_o <= RMAX;
    else if (dec_i && rate_o != '0) rate_o <= rate_o - RATE_W'(1);
  end

  assign at_min_o    = (rate_o == '0);
  assign below_max_o = (rate_o < RMAX);

  p_rate_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_o <= RMAX);
  p_step_one_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !clr_i && !ld_max_i && !at_min_o) |=> rate_o == $past(rate_o) - RATE_W'(1));
endmodule

// File: rtl/link_train_fsm.sv
module link_train_fsm
  import lt_pkg::*;
#(
  parameter int TMO_CYC  = 1024,
  parameter int MAX_RATE = 4,
  parameter int IVAL_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_detect_i,
  input  logic              lock_i,
  input  logic              cfg_done_i,
  input  logic              eq_done_i,
  input  logic              eq_fail_i,
  input  logic [1:0]        pwr_req_i,
  input  logic [IVAL_W-1:0] retry_ival_i,
  output logic [2:0]        state_o,
  output logic [2:0]        rate_o,
  output logic              eq_start_o
);
  localparam int TW = $clog2(TMO_CYC + 1);

  lt_state_e         state_q, state_d;
  logic [TW-1:0]     tcnt;
  logic [IVAL_W-1:0] rcnt;
  logic              tmo, chg, restart, ld_max, dec, clr_rate;
  logic              at_min, below_max, eq_q;
  logic [RATE_W-1:0] rate;

  assign tmo = (tcnt == TW'(TMO_CYC - 1));

  always_comb begin
    state_d = state_q;
    restart = 1'b0;
    ld_max  = 1'b0;
    dec     = 1'b0;
    unique case (state_q)
      ST_DETECT: if (rx_detect_i) state_d = ST_POLL;
      ST_POLL: begin
        if (lock_i)   state_d = ST_CFG;
        else if (tmo) state_d = ST_DETECT;
      end
      ST_CFG: begin
        if (cfg_done_i) begin
          state_d = ST_RECOV;
          ld_max  = 1'b1;
        end else if (tmo) state_d = ST_DETECT;
      end
      ST_RECOV: begin
        if (eq_done_i) state_d = ST_L0;
        else if (eq_fail_i || tmo) begin
          if (at_min) state_d = ST_DETECT;
          else begin
            dec     = 1'b1;
            restart = 1'b1;
          end
        end
      end
      ST_L0: begin
        if (pwr_req_i != 2'd0) begin
          unique case (pwr_req_i)
            2'd1:    state_d = ST_L0S;
            2'd2:    state_d = ST_L1;
            default: state_d = ST_L2;
          endcase
        end else if (below_max && rcnt >= retry_ival_i) begin
          state_d = ST_RECOV;
          ld_max  = 1'b1;
        end
      end
      ST_L0S: if (pwr_req_i == 2'd0) state_d = ST_L0;
      ST_L1:  if (pwr_req_i == 2'd0) state_d = ST_RECOV;
      default: if (pwr_req_i == 2'd0) state_d = ST_DETECT;
    endcase
  end

  assign chg      = (state_d != state_q);
  assign clr_rate = (state_d == ST_DETECT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_DETECT;
      eq_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      eq_q    <= (state_d == ST_RECOV) && (chg || restart);
    end
  end

  lt_timer #(.W(TW)) u_wait_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (chg || restart),
    .en_i   (state_q inside {ST_POLL, ST_CFG, ST_RECOV}),
    .cnt_o  (tcnt)
  );

  lt_timer #(.W(IVAL_W)) u_retry_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (chg),
    .en_i   (state_q == ST_L0 && below_max),
    .cnt_o  (rcnt)
  );

  lt_rate_ctl #(.MAX_RATE(MAX_RATE)) u_rate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ld_max_i    (ld_max),
    .dec_i       (dec),
    .clr_i       (clr_rate),
    .rate_o      (rate),
    .at_min_o    (at_min),
    .below_max_o (below_max)
  );

  assign state_o    = state_q;
  assign rate_o     = rate;
  assign eq_start_o = eq_q;

  p_eq_in_recov_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eq_q |-> state_q == ST_RECOV);
  p_poll_exit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_POLL |=> state_q inside {ST_POLL, ST_CFG, ST_DETECT});
  p_tmo_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_POLL, ST_CFG, ST_RECOV}) |-> tcnt < TW'(TMO_CYC));
  p_done_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECOV && eq_done_i) |=> state_q == ST_L0);
  p_fallback_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECOV && !eq_done_i && eq_fail_i && rate != '0) |=> (state_q == ST_RECOV && eq_q));
  p_min_fail_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECOV && !eq_done_i && eq_fail_i && rate == '0) |=> state_q == ST_DETECT);
  p_l2_exit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_L2 |=> state_q inside {ST_L2, ST_DETECT});
endmodule

// File: tb/link_train_fsm_bench.sv
module link_train_fsm_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TMO  = 8;
  localparam int MAXR = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_det = 0, lock = 0, cfg = 0, eqd = 0, eqf = 0;
  logic [1:0]  pwr = 0;
  logic [15:0] ival = 16'd1000;
  logic [2:0]  st, rt;
  logic        eqs;

  int checks = 0, fails = 0, cyc_cnt = 0;
  string tag = "R1";
  int ms = 0, mr = 0, mt = 0, mq = 0;
  bit meq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_train_fsm #(.TMO_CYC(TMO), .MAX_RATE(MAXR), .IVAL_W(16)) u_link_train_fsm (
    .clk_i(clk), .rst_ni(rst_n), .rx_detect_i(rx_det), .lock_i(lock),
    .cfg_done_i(cfg), .eq_done_i(eqd), .eq_fail_i(eqf), .pwr_req_i(pwr),
    .retry_ival_i(ival), .state_o(st), .rate_o(rt), .eq_start_o(eqs)
  );

  // behavioural reference
  always @(posedge clk) begin
    int ns;
    bit rs;
    if (!rst_n) begin
      ms = 0; mr = 0; mt = 0; mq = 0; meq = 0;
    end else begin
      ns = ms; rs = 0;
      case (ms)
        0: if (rx_det) ns = 1;
        1: if (lock) ns = 2; else if (mt == TMO-1) ns = 0;
        2: if (cfg) begin ns = 3; mr = MAXR; end else if (mt == TMO-1) ns = 0;
        3: if (eqd) ns = 4;
           else if (eqf || mt == TMO-1) begin
             if (mr == 0) ns = 0; else begin mr = mr - 1; rs = 1; end
           end
        4: if (pwr != 0) ns = 4 + pwr;
           else if (mr < MAXR && mq >= ival) begin ns = 3; mr = MAXR; end
        5: if (pwr == 0) ns = 4;
        6: if (pwr == 0) ns = 3;
        default: if (pwr == 0) ns = 0;
      endcase
      if (ns == 0) mr = 0;
      meq = (ns == 3) && (ns != ms || rs);
      if (ns != ms || rs) mt = 0; else if (ms >= 1 && ms <= 3) mt = mt + 1;
      if (ns != ms) mq = 0; else if (ms == 4 && mr < MAXR) mq = mq + 1;
      ms = ns;
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc_cnt++;
    if (rst_n) begin
      chk(tag, int'(st), ms, "state");
      chk(tag, int'(rt), mr, "rate");
      chk(tag, int'(eqs), int'(meq), "eq_start");
    end
    if (cyc_cnt > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", cyc_cnt);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_eqd();
    eqd = 1; cyc(1); eqd = 0;
  endtask

  initial begin
    cyc(3);
    chk("R1", int'(st), 0, "reset state");
    chk("R1", int'(rt), 0, "reset rate");
    chk("R1", int'(eqs), 0, "reset eq_start");
    rst_n = 1; cyc(2);
    // bring-up with one fallback
    tag = "R2"; rx_det = 1; cyc(1); rx_det = 0; cyc(1);
    chk("R2", int'(st), 1, "polling");
    lock = 1; cyc(1); lock = 0; cyc(1);
    tag = "R4"; cfg = 1; cyc(1); cfg = 0;
    chk("R4", int'(rt), 4, "top rate on entry");
    chk("R4", int'(eqs), 1, "eq strobe on entry");
    cyc(2);
    tag = "R6"; eqf = 1; cyc(1); eqf = 0;
    chk("R6", int'(rt), 3, "one-step fallback");
    cyc(3);
    tag = "R6"; cyc(TMO);
    chk("R6", int'(rt), 2, "fallback on timeout");
    tag = "R5"; pulse_eqd(); cyc(3);
    chk("R5", int'(st), 4, "L0 reached");
    // retry of top rate
    tag = "R8"; ival = 16'd5; cyc(8);
    chk("R8", int'(rt), 4, "retry at top rate");
    pulse_eqd(); cyc(20);
    chk("R8", int'(st), 4, "no retry at top rate");
    // power states
    tag = "R9"; pwr = 1; cyc(3);
    tag = "R10"; pwr = 0; cyc(2);
    tag = "R9"; pwr = 2; cyc(3);
    tag = "R10"; pwr = 0; cyc(2); pulse_eqd(); cyc(2);
    tag = "R9"; pwr = 3; cyc(3);
    tag = "R10"; pwr = 0; cyc(2);
    chk("R10", int'(st), 0, "L2 exit to detect");
    chk("R10", int'(rt), 0, "rate cleared");
    // timeouts in polling and configuration
    tag = "R3"; rx_det = 1; cyc(1); rx_det = 0; cyc(TMO + 3);
    chk("R3", int'(st), 0, "polling timeout");
    rx_det = 1; cyc(1); rx_det = 0; lock = 1; cyc(1); lock = 0; cyc(TMO + 3);
    chk("R3", int'(st), 0, "config timeout");
    // full descent to base rate then detect
    tag = "R7"; rx_det = 1; cyc(1); rx_det = 0; lock = 1; cyc(1); lock = 0;
    cfg = 1; cyc(1); cfg = 0;
    cyc(5 * TMO + 3);
    chk("R7", int'(st), 0, "base-rate failure to detect");
    // fast fail chain with eq_fail held
    rx_det = 1; cyc(1); rx_det = 0; lock = 1; cyc(1); lock = 0;
    cfg = 1; cyc(1); cfg = 0; eqf = 1; cyc(7); eqf = 0; cyc(2);
    chk("R7", int'(st), 0, "held fail to detect");
    // done beats fail; power beats retry; L1 keeps rate
    tag = "R5"; rx_det = 1; cyc(1); rx_det = 0; lock = 1; cyc(1); lock = 0;
    cfg = 1; cyc(1); cfg = 0; eqf = 1; cyc(1);
    eqd = 1; cyc(1); eqd = 0; eqf = 0;
    chk("R5", int'(st), 4, "done wins over fail");
    tag = "R9"; ival = 16'd0; pwr = 2; cyc(1);
    chk("R9", int'(st), 6, "power wins over retry");
    tag = "R10"; pwr = 0; cyc(1);
    chk("R10", int'(rt), 3, "L1 exit keeps rate");
    tag = "R8"; pulse_eqd(); cyc(3);
    chk("R8", int'(rt), 4, "zero interval retry");
    cyc(3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule